// File: doc/BRIEF.md
# Byte-Misalignment Extraction Unit

This unit lets software pull an unaligned 8-byte item out of two aligned 8-byte words. It runs two operations. The first, address-align, adds two 64-bit operands. It returns the sum rounded down to an 8-byte boundary, and it records the leftover byte offset in a 3-bit offset field of a status register. The second, data-align, joins two 64-bit operands into a 16-byte window and extracts the 8 bytes that start at the recorded offset.

The offset can be recorded in two ways. In big-endian mode it is the sum's low three bits. In little-endian mode it is the two's-complement negation of the sum, kept to three bits. A separate port reads and writes the whole status register. Both operations are registered: a result appears one cycle after the operation is presented with its valid.

Top module: `byte_align_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `sr_rd_data` is all zeros.
- R2: An address-align (`in_op` = 0) gives `out_data` = (`in_a` + `in_b`) modulo 2^64 with bits [2:0] cleared.
- R3: An address-align with `in_le` = 0 writes (`in_a` + `in_b`) & 7 into status bits [2:0]. All other status bits keep their value.
- R4: An address-align with `in_le` = 1 writes (-(`in_a` + `in_b`)) & 7 into status bits [2:0].
- R5: A data-align (`in_op` = 1) with offset k = status bits [2:0] gives the 64 bits of the 128-bit value {`in_a`,`in_b`} that begin k bytes below its top byte. That is (`in_a` << 8k) | (`in_b` >> (64-8k)).
- R6: A data-align with k = 0 returns `in_a` exactly, with nothing from `in_b`.
- R7: A data-align presented in the cycle right after an address-align uses the offset that address-align produced.
- R8: A status write (`sr_wr` = 1) loads `sr_wr_data` into the status register, which `sr_rd_data` shows from the next cycle. If an address-align is presented in the same cycle, bits [2:0] take the address-align offset and the other bits take `sr_wr_data`.
- R9: `out_valid` is 1 exactly one cycle after `in_valid` was 1, and 0 otherwise. A data-align leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 1 | 0 = address-align, 1 = data-align |
| in_le | input | 1 | Offset mode for address-align: 0 big-endian, 1 little-endian |
| in_a | input | 64 | First operand; upper 8 bytes of the window for data-align |
| in_b | input | 64 | Second operand; lower 8 bytes of the window for data-align |
| sr_wr | input | 1 | Status register write strobe |
| sr_wr_data | input | 64 | Status register write value |
| sr_rd_data | output | 64 | Current status register value |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Result |

## Verification
The status write port and an address-align can both land in the same cycle, and both want bits [2:0]. The bench provokes this by driving a status write with a distinctive pattern together with an address-align. After the clock edge, it reads the register back and expects the upper bits from the write data and the low field from the computed offset. It also issues a data-align right after the collision, to confirm that the operation's offset is the one that survived.

// File: rtl/byte_align_unit.sv
module byte_align_unit #(
  parameter int DATA_W = 64,
  parameter int SR_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_op,
  input  logic              in_le,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              sr_wr,
  input  logic [SR_W-1:0]   sr_wr_data,
  output logic [SR_W-1:0]   sr_rd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int NBYTES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NBYTES);
  localparam int SH_W   = OFF_W + 3;

  logic [SR_W-1:0]     sr_q;
  logic [DATA_W-1:0]   sum;
  logic [OFF_W-1:0]    k;
  logic [OFF_W-1:0]    le_off;
  logic [OFF_W-1:0]    new_off;
  logic [SH_W-1:0]     sh_amt;
  logic [2*DATA_W-1:0] window;
  logic [DATA_W-1:0]   aligned_addr;
  logic                do_addr;

  assign sum          = in_a + in_b;
  assign le_off       = ~sum[OFF_W-1:0] + {{(OFF_W-1){1'b0}}, 1'b1};
  assign new_off      = in_le ? le_off : sum[OFF_W-1:0];
  assign k            = sr_q[OFF_W-1:0];
  assign sh_amt       = {k, 3'b000};
  assign window       = {in_a, in_b} << sh_amt;
  assign aligned_addr = {sum[DATA_W-1:OFF_W], {OFF_W{1'b0}}};
  assign do_addr      = in_valid && !in_op;
  assign sr_rd_data   = sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      if (sr_wr)   sr_q <= sr_wr_data;
      if (do_addr) sr_q[OFF_W-1:0] <= new_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_op ? window[2*DATA_W-1:DATA_W] : aligned_addr;
    end
  end
endmodule

// File: rtl/byte_align_unit_chk.sv
module byte_align_unit_chk #(
  parameter int DATA_W = 64,
  parameter int SR_W   = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_op,
  input logic              in_le,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              sr_wr,
  input logic [SR_W-1:0]   sr_wr_data,
  input logic [SR_W-1:0]   sr_rd_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_addr_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op) |=> (out_data[OFF_W-1:0] == '0));
  a_r3_be_field: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op && !in_le) |=>
      (sr_rd_data[OFF_W-1:0] == OFF_W'($past(in_a) + $past(in_b))));
  a_r4_le_field: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op && in_le) |=>
      (sr_rd_data[OFF_W-1:0] == OFF_W'(-($past(in_a) + $past(in_b)))));
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op && !sr_wr) |=>
      (sr_rd_data[SR_W-1:OFF_W] == $past(sr_rd_data[SR_W-1:OFF_W])));
  a_r8_collision_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op && sr_wr) |=>
      (sr_rd_data[SR_W-1:OFF_W] == $past(sr_wr_data[SR_W-1:OFF_W])));
  a_r9_data_keeps_sr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op && !sr_wr) |=> $stable(sr_rd_data));
  a_r6_zero_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op && sr_rd_data[OFF_W-1:0] == '0) |=> (out_data == $past(in_a)));
endmodule

bind byte_align_unit byte_align_unit_chk #(.DATA_W(DATA_W), .SR_W(SR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_le(in_le),
  .in_a(in_a), .in_b(in_b), .sr_wr(sr_wr), .sr_wr_data(sr_wr_data),
  .sr_rd_data(sr_rd_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_byte_align_unit.sv
module sim_byte_align_unit;
  localparam time PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_op = 1'b0, in_le = 1'b0, sr_wr = 1'b0;
  logic [63:0] in_a = '0, in_b = '0, sr_wr_data = '0;
  logic [63:0] sr_rd_data, out_data;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  logic [63:0] model_sr = '0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  bit          active = 1'b0;

  byte_align_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_le(in_le),
    .in_a(in_a), .in_b(in_b), .sr_wr(sr_wr), .sr_wr_data(sr_wr_data),
    .sr_rd_data(sr_rd_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] ref_dalign(logic [63:0] a, logic [63:0] b, int k);
    if (k == 0) return a;
    return (a << (8*k)) | (b >> (64 - 8*k));
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(bit op, bit le, logic [63:0] a, logic [63:0] b,
                       bit wr, logic [63:0] wdata, string tag);
    logic [63:0] s;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_le = le; in_a = a; in_b = b;
    sr_wr = wr; sr_wr_data = wdata;
    s = a + b;
    if (op) exp_q.push_back(ref_dalign(a, b, int'(model_sr[2:0])));
    else    exp_q.push_back(s & ~64'd7);
    tag_q.push_back(tag);
    if (wr) model_sr = wdata;
    if (!op) model_sr[2:0] = le ? 3'((~s) + 64'd1) : s[2:0];
  endtask

  task automatic sr_write(logic [63:0] wdata);
    @(negedge clk);
    in_valid = 1'b0; sr_wr = 1'b1; sr_wr_data = wdata;
    model_sr = wdata;
  endtask

  task automatic idle_check_sr(string req);
    @(negedge clk);
    in_valid = 1'b0; sr_wr = 1'b0;
    check(sr_rd_data == model_sr, req, sr_rd_data, model_sr);
  endtask

  always @(negedge clk) begin
    if (active) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected out_valid", 64'd1, 64'd0);
        end else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", {63'd0, out_valid}, 64'd0);
    check(sr_rd_data == '0, "R1 sr in reset", sr_rd_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", {63'd0, out_valid}, 64'd0);
    check(sr_rd_data == '0, "R1 sr after reset", sr_rd_data, 64'd0);
    active = 1'b1;

    // R8 write whole register, then R3 upper bits survive address-align
    sr_write(64'hA5A5_0000_1234_5670);
    idle_check_sr("R8 status write");
    drive(1'b0, 1'b0, 64'h0000_0000_0000_1003, 64'd4, 1'b0, '0, "R2 addr-align BE");
    drive(1'b1, 1'b0, 64'h0011_2233_4455_6677, 64'h8899_AABB_CCDD_EEFF, 1'b0, '0,
          "R7 data-align after addr-align k=7");
    idle_check_sr("R3 BE field with upper kept");
    check(sr_rd_data[2:0] == 3'd7, "R3 field value", {61'd0, sr_rd_data[2:0]}, 64'd7);

    // R4 little-endian mode: sum low bits 5 -> offset 3
    drive(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h15, 1'b0, '0, "R2 addr-align LE wrap");
    drive(1'b1, 1'b0, 64'h0102_0304_0506_0708, 64'h090A_0B0C_0D0E_0F10, 1'b0, '0,
          "R5 R7 data-align k=3");
    idle_check_sr("R4 LE field");
    check(sr_rd_data[2:0] == 3'd3, "R4 field value", {61'd0, sr_rd_data[2:0]}, 64'd3);

    // R6 zero offset
    sr_write(64'hDEAD_BEEF_0000_0000);
    drive(1'b1, 1'b1, 64'hCAFE_F00D_1357_9BDF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, '0,
          "R6 data-align k=0");
    idle_check_sr("R9 data-align keeps sr");

    // R8 collision: status write with address-align
    drive(1'b0, 1'b0, 64'h100, 64'h6, 1'b1, 64'h7777_6666_5555_4440,
          "R2 addr-align during sr write");
    drive(1'b1, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 1'b0, '0,
          "R8 data-align after collision k=6");
    idle_check_sr("R8 collision merge");
    check(sr_rd_data == 64'h7777_6666_5555_4446, "R8 collision value",
          sr_rd_data, 64'h7777_6666_5555_4446);

    // R5 sweep all offsets via address-align setting k
    for (int k = 0; k < 8; k++) begin
      drive(1'b0, 1'b0, 64'h8000, 64'(k), 1'b0, '0, "R2 sweep addr");
      drive(1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0, '0,
            "R5 sweep data-align");
    end

    // Mixed random traffic
    for (int i = 0; i < 60; i++) begin
      drive(1'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
            1'b0, '0, "R5 R2 random mix");
    end
    idle_check_sr("R3 R4 sr after random mix");

    // R9 valid drops when idle
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R9 idle valid low", {63'd0, out_valid}, 64'd0);
    check(exp_q.size() == 0, "R9 all results seen", 64'(exp_q.size()), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule